// File: doc/BRIEF.md
# Shared DRAM Arbiter with Posted CPU Write Buffer

This block lets a rendering engine and a general-purpose CPU core share one DRAM command port that sits on the graphics-side bus. The rendering engine holds fixed priority: whenever it is requesting and the DRAM side is free, it gets the next DRAM access. CPU accesses to its own local bus, such as instruction fetches or reads from boot memory, never go through the arbiter. They are acknowledged in the cycle they are presented, and their data comes from the local read bus.

CPU writes to DRAM go into a one-word posted buffer that holds both the address and the data. The CPU sees a write with zero wait states whenever the buffer is empty. The buffered word is written to DRAM only when the rendering engine is not requesting. A CPU read to DRAM whose address matches the buffered word is served from the buffer. Any other DRAM read waits until the buffer is empty and the rendering engine is idle.

Only one DRAM command is issued at a time. It is a single-cycle pulse at the start of a grant, and the grant lasts until the DRAM side reports completion.

Top module: `dram_share_arbiter`

## Requirements
- R1: A CPU request whose address has its top bit at 0 (local bus) is acknowledged in the same cycle with `loc_rdata` on `cpu_rdata`. This holds even while the rendering engine owns DRAM, and such a request never starts a DRAM command.
- R2: A CPU write with the address top bit at 1 (DRAM) is acknowledged in the same cycle when the write buffer is empty, and its address and data are captured into the buffer.
- R3: A CPU DRAM write presented while the buffer is full gets no acknowledge until the cycle after the buffer's drain completes.
- R4: When the arbiter is idle and `gfx_req` is high, the rendering engine is granted even if a buffered write or a CPU read is pending. The command carries the rendering engine's address, data and write flag.
- R5: The buffered word is sent to DRAM with write flag 1 and the buffered address and data, and only from an idle cycle in which `gfx_req` is low. The buffer empties when that command completes.
- R6: A CPU DRAM read whose address equals the buffered address is acknowledged in the same cycle with the buffered data.
- R7: A CPU DRAM read that misses a full buffer waits while the buffer drains. After the drain it is issued as a read command (write flag 0, CPU address) once the arbiter is idle with no `gfx_req`, and it is acknowledged in the cycle `dram_done` is high, with `dram_rdata` on `cpu_rdata`.
- R8: `dram_cmd_valid` is high for exactly the first cycle of each grant. The owner, including `gfx_gnt`, stays unchanged until `dram_done`.
- R9: After reset there is no grant, no DRAM command and no acknowledge, and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU access request, held until acknowledged |
| cpu_we | input | 1 | CPU write (1) or read (0) |
| cpu_addr | input | AW | CPU address; top bit 1 selects DRAM |
| cpu_wdata | input | DW | CPU write data |
| cpu_rdata | output | DW | CPU read data |
| cpu_ack | output | 1 | CPU access complete this cycle |
| loc_rdata | input | DW | Read data from the CPU local bus |
| gfx_req | input | 1 | Rendering engine DRAM request |
| gfx_we | input | 1 | Rendering engine write flag |
| gfx_addr | input | AW | Rendering engine address |
| gfx_wdata | input | DW | Rendering engine write data |
| gfx_gnt | output | 1 | Rendering engine owns DRAM |
| dram_cmd_valid | output | 1 | Single-cycle DRAM command strobe |
| dram_cmd_we | output | 1 | DRAM command write flag |
| dram_cmd_addr | output | AW | DRAM command address |
| dram_cmd_wdata | output | DW | DRAM command write data |
| dram_rdata | input | DW | DRAM read data, valid with dram_done |
| dram_done | input | 1 | DRAM access complete |

## Verification
The bench builds the block with AW=12 and DW=16, so bit 11 is the DRAM select bit. Short literal addresses can then land on either side of the decode. With 16-bit data, the buffered word, the DRAM return word and the local word are all distinct, so a wrong source on `cpu_rdata` shows up in the read data. The DRAM completion is driven by hand. This lets the bench hold a grant open across a stalled write, a buffer hit and a repeated rendering request, and then release the buffered write and a missed read one at a time.

// File: rtl/dram_arb_pkg.sv
package dram_arb_pkg;
    typedef enum logic [1:0] {
        OWN_IDLE  = 2'd0,
        OWN_GFX   = 2'd1,
        OWN_WBUF  = 2'd2,
        OWN_CPURD = 2'd3
    } owner_e;
endpackage

// File: rtl/dram_wbuf.sv
module dram_wbuf #(
    parameter int AW = 24,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic [DW-1:0] load_data,
    input  logic          drain_done,
    input  logic [AW-1:0] rd_addr,
    output logic          valid,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] data,
    output logic          hit
);
    typedef struct packed {
        logic          valid;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } wb_t;

    wb_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (drain_done) begin
            st_d.valid = 1'b0;
        end
        if (load) begin
            st_d.valid = 1'b1;
            st_d.addr  = load_addr;
            st_d.data  = load_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid = st_q.valid;
    assign addr  = st_q.addr;
    assign data  = st_q.data;
    assign hit   = st_q.valid && (st_q.addr == rd_addr);

    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !st_q.valid); // R3
    AST_DRAIN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        drain_done |=> !st_q.valid); // R5
endmodule

// File: rtl/dram_arb_core.sv
module dram_arb_core
    import dram_arb_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gfx_req,
    input  logic          gfx_we,
    input  logic [AW-1:0] gfx_addr,
    input  logic [DW-1:0] gfx_wdata,
    input  logic          buf_valid,
    input  logic [AW-1:0] buf_addr,
    input  logic [DW-1:0] buf_data,
    input  logic          cpu_rd_req,
    input  logic [AW-1:0] cpu_addr,
    input  logic          dram_done,
    output owner_e        owner,
    output logic          cmd_valid,
    output logic          cmd_we,
    output logic [AW-1:0] cmd_addr,
    output logic [DW-1:0] cmd_wdata,
    output logic          drain_done
);
    typedef struct packed {
        owner_e        owner;
        logic          cmd_valid;
        logic          cmd_we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } arb_t;

    arb_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.cmd_valid = 1'b0;
        if (st_q.owner == OWN_IDLE) begin
            if (gfx_req) begin
                st_d.owner     = OWN_GFX;
                st_d.cmd_valid = 1'b1;
                st_d.cmd_we    = gfx_we;
                st_d.addr      = gfx_addr;
                st_d.wdata     = gfx_wdata;
            end else if (buf_valid) begin
                st_d.owner     = OWN_WBUF;
                st_d.cmd_valid = 1'b1;
                st_d.cmd_we    = 1'b1;
                st_d.addr      = buf_addr;
                st_d.wdata     = buf_data;
            end else if (cpu_rd_req) begin
                st_d.owner     = OWN_CPURD;
                st_d.cmd_valid = 1'b1;
                st_d.cmd_we    = 1'b0;
                st_d.addr      = cpu_addr;
                st_d.wdata     = '0;
            end
        end else if (dram_done) begin
            st_d.owner = OWN_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{owner: OWN_IDLE, cmd_valid: 1'b0, cmd_we: 1'b0,
                      addr: '0, wdata: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign owner      = st_q.owner;
    assign cmd_valid  = st_q.cmd_valid;
    assign cmd_we     = st_q.cmd_we;
    assign cmd_addr   = st_q.addr;
    assign cmd_wdata  = st_q.wdata;
    assign drain_done = (st_q.owner == OWN_WBUF) && dram_done;

    AST_GFX_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.owner == OWN_IDLE && gfx_req) |=> (st_q.owner == OWN_GFX)); // R4
    AST_DRAIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.owner == OWN_WBUF && st_q.cmd_valid) |-> !$past(gfx_req)); // R5
    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cmd_valid |=> !st_q.cmd_valid); // R8
    AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.owner != OWN_IDLE && !dram_done) |=> $stable(st_q.owner)); // R8
    AST_CMD_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cmd_valid |-> (st_q.owner != OWN_IDLE)); // R8
endmodule

// File: rtl/dram_share_arbiter.sv
module dram_share_arbiter
    import dram_arb_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    output logic          cpu_ack,
    input  logic [DW-1:0] loc_rdata,
    input  logic          gfx_req,
    input  logic          gfx_we,
    input  logic [AW-1:0] gfx_addr,
    input  logic [DW-1:0] gfx_wdata,
    output logic          gfx_gnt,
    output logic          dram_cmd_valid,
    output logic          dram_cmd_we,
    output logic [AW-1:0] dram_cmd_addr,
    output logic [DW-1:0] dram_cmd_wdata,
    input  logic [DW-1:0] dram_rdata,
    input  logic          dram_done
);
    localparam int SEL_BIT = AW - 1;

    logic          is_dram, dram_wr, dram_rd;
    logic          buf_load, buf_valid, buf_hit, drain_done;
    logic [AW-1:0] buf_addr;
    logic [DW-1:0] buf_data;
    logic          cpu_rd_req;
    owner_e        owner;
    logic          rd_done;

    always_comb begin
        is_dram    = cpu_addr[SEL_BIT];
        dram_wr    = cpu_req && is_dram && cpu_we;
        dram_rd    = cpu_req && is_dram && !cpu_we;
        buf_load   = dram_wr && !buf_valid;
        cpu_rd_req = dram_rd && !buf_valid;
        rd_done    = (owner == OWN_CPURD) && dram_done;
        cpu_ack    = 1'b0;
        cpu_rdata  = '0;
        if (cpu_req && !is_dram) begin
            cpu_ack   = 1'b1;
            cpu_rdata = loc_rdata;
        end else if (buf_load) begin
            cpu_ack = 1'b1;
        end else if (dram_rd && buf_hit) begin
            cpu_ack   = 1'b1;
            cpu_rdata = buf_data;
        end else if (dram_rd && rd_done) begin
            cpu_ack   = 1'b1;
            cpu_rdata = dram_rdata;
        end
    end

    dram_wbuf #(.AW(AW), .DW(DW)) u_wbuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (buf_load),
        .load_addr  (cpu_addr),
        .load_data  (cpu_wdata),
        .drain_done (drain_done),
        .rd_addr    (cpu_addr),
        .valid      (buf_valid),
        .addr       (buf_addr),
        .data       (buf_data),
        .hit        (buf_hit)
    );

    dram_arb_core #(.AW(AW), .DW(DW)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .gfx_req    (gfx_req),
        .gfx_we     (gfx_we),
        .gfx_addr   (gfx_addr),
        .gfx_wdata  (gfx_wdata),
        .buf_valid  (buf_valid),
        .buf_addr   (buf_addr),
        .buf_data   (buf_data),
        .cpu_rd_req (cpu_rd_req),
        .cpu_addr   (cpu_addr),
        .dram_done  (dram_done),
        .owner      (owner),
        .cmd_valid  (dram_cmd_valid),
        .cmd_we     (dram_cmd_we),
        .cmd_addr   (dram_cmd_addr),
        .cmd_wdata  (dram_cmd_wdata),
        .drain_done (drain_done)
    );

    assign gfx_gnt = (owner == OWN_GFX);

    AST_POSTED_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && cpu_req && is_dram && cpu_we) |=> buf_valid); // R2
    AST_READ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (owner == OWN_CPURD && dram_cmd_valid) |-> $past(!gfx_req && !buf_valid)); // R7
    AST_LOCAL_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (owner == OWN_IDLE && !gfx_req && !buf_valid && cpu_req && !is_dram)
        |=> !dram_cmd_valid); // R1
endmodule

// File: tb/tb_dram_share_arbiter.sv
module tb_dram_share_arbiter;
    localparam int AW = 12;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cpu_req, cpu_we;
    logic [AW-1:0] cpu_addr;
    logic [DW-1:0] cpu_wdata, cpu_rdata, loc_rdata;
    logic          cpu_ack;
    logic          gfx_req, gfx_we, gfx_gnt;
    logic [AW-1:0] gfx_addr;
    logic [DW-1:0] gfx_wdata;
    logic          dram_cmd_valid, dram_cmd_we, dram_done;
    logic [AW-1:0] dram_cmd_addr;
    logic [DW-1:0] dram_cmd_wdata, dram_rdata;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    localparam logic [AW-1:0] G1 = 12'hC10;
    localparam logic [AW-1:0] A1 = 12'h8A0;
    localparam logic [AW-1:0] A2 = 12'h8B4;
    localparam logic [AW-1:0] A3 = 12'h9F0;
    localparam logic [DW-1:0] D1 = 16'h1234;
    localparam logic [DW-1:0] D2 = 16'hA5C3;
    localparam logic [DW-1:0] RD = 16'h5A5A;

    always #2 clk = ~clk;

    dram_share_arbiter #(.AW(AW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack),
        .loc_rdata(loc_rdata),
        .gfx_req(gfx_req), .gfx_we(gfx_we), .gfx_addr(gfx_addr),
        .gfx_wdata(gfx_wdata), .gfx_gnt(gfx_gnt),
        .dram_cmd_valid(dram_cmd_valid), .dram_cmd_we(dram_cmd_we),
        .dram_cmd_addr(dram_cmd_addr), .dram_cmd_wdata(dram_cmd_wdata),
        .dram_rdata(dram_rdata), .dram_done(dram_done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; cpu_req = 0; cpu_we = 0; cpu_addr = '0; cpu_wdata = '0;
        loc_rdata = '0; gfx_req = 0; gfx_we = 0; gfx_addr = '0; gfx_wdata = '0;
        dram_done = 0; dram_rdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R9 gnt", gfx_gnt, 0);
        chk("R9 cmd", dram_cmd_valid, 0);
        chk("R9 ack", cpu_ack, 0);
        cpu_req = 1; cpu_we = 0; cpu_addr = A1; #1;
        chk("R9 empty buffer gives no hit", cpu_ack, 0);
        cpu_req = 0;
    endtask

    task automatic t_local();
        @(negedge clk); gfx_req = 1; gfx_we = 1; gfx_addr = 12'hC00; gfx_wdata = 16'h0F0F;
        @(negedge clk); cpu_req = 1; cpu_we = 0; cpu_addr = 12'h123; loc_rdata = 16'hBEEF; #1;
        chk("R1 local read ack", cpu_ack, 1);
        chk("R1 local read data", cpu_rdata, 16'hBEEF);
        chk("R1 gfx owns DRAM meanwhile", gfx_gnt, 1);
        dram_done = 1; gfx_req = 0;
        @(negedge clk); dram_done = 0; cpu_we = 1; cpu_addr = 12'h045; #1;
        chk("R1 local write ack", cpu_ack, 1);
        @(negedge clk); cpu_req = 0; #1;
        chk("R1 no DRAM command", dram_cmd_valid, 0);
        chk("R8 grant released", gfx_gnt, 0);
    endtask

    task automatic t_post_and_hit();
        @(negedge clk);
        gfx_req = 1; gfx_we = 0; gfx_addr = G1; gfx_wdata = 16'h7777;
        cpu_req = 1; cpu_we = 1; cpu_addr = A1; cpu_wdata = D1; #1;
        chk("R2 posted write ack", cpu_ack, 1);
        @(negedge clk); cpu_req = 0; #1;
        chk("R4 gfx granted", gfx_gnt, 1);
        chk("R8 cmd pulse", dram_cmd_valid, 1);
        chk("R4 cmd we", dram_cmd_we, 0);
        chk("R4 cmd addr", dram_cmd_addr, G1);
        @(negedge clk); cpu_req = 1; cpu_we = 0; cpu_addr = A1; #1;
        chk("R6 hit ack", cpu_ack, 1);
        chk("R6 hit data", cpu_rdata, D1);
        chk("R8 pulse one cycle", dram_cmd_valid, 0);
        chk("R8 grant held", gfx_gnt, 1);
    endtask

    task automatic t_full_stall();
        @(negedge clk); cpu_we = 1; cpu_addr = A2; cpu_wdata = D2; dram_done = 1; #1;
        chk("R3 stall while full", cpu_ack, 0);
        @(negedge clk); dram_done = 0; #1;
        chk("R3 still stalled", cpu_ack, 0);
        chk("R8 grant ends after done", gfx_gnt, 0);
        @(negedge clk); #1;
        chk("R4 gfx beats buffer", gfx_gnt, 1);
        chk("R5 no drain under gfx", dram_cmd_addr, G1);
        gfx_req = 0; dram_done = 1;
        @(negedge clk); dram_done = 0; #1;
        chk("R8 idle cycle", dram_cmd_valid, 0);
        chk("R3 stalled during idle", cpu_ack, 0);
        @(negedge clk); #1;
        chk("R5 drain cmd", dram_cmd_valid, 1);
        chk("R5 drain we", dram_cmd_we, 1);
        chk("R5 drain addr", dram_cmd_addr, A1);
        chk("R5 drain data", dram_cmd_wdata, D1);
        chk("R3 stalled during drain", cpu_ack, 0);
        dram_done = 1;
        @(negedge clk); dram_done = 0; #1;
        chk("R3 ack after drain", cpu_ack, 1);
    endtask

    task automatic t_read_miss();
        @(negedge clk); cpu_we = 0; cpu_addr = A3; #1;
        chk("R7 miss waits", cpu_ack, 0);
        @(negedge clk); #1;
        chk("R5 second drain addr", dram_cmd_addr, A2);
        chk("R5 second drain data", dram_cmd_wdata, D2);
        chk("R7 waits during drain", cpu_ack, 0);
        dram_done = 1;
        @(negedge clk); dram_done = 0; #1;
        chk("R7 not yet issued", dram_cmd_valid, 0);
        chk("R7 no ack yet", cpu_ack, 0);
        @(negedge clk); #1;
        chk("R7 read cmd", dram_cmd_valid, 1);
        chk("R7 read we", dram_cmd_we, 0);
        chk("R7 read addr", dram_cmd_addr, A3);
        chk("R7 no ack before done", cpu_ack, 0);
        dram_rdata = RD; dram_done = 1; #1;
        chk("R7 ack on done", cpu_ack, 1);
        chk("R7 read data", cpu_rdata, RD);
        @(negedge clk); dram_done = 0; cpu_req = 0; #1;
        chk("R8 quiet after read", dram_cmd_valid, 0);
        chk("R8 no grant", gfx_gnt, 0);
    endtask

    initial begin
        t_reset();
        t_local();
        t_post_and_hit();
        t_full_stall();
        t_read_miss();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule